// File: doc/BRIEF.md
# Return Address Stack and Context Flag Controller

This block holds the return addresses of a small 8-bit controller core and switches its carry/zero flag context. A subroutine call pushes the return program counter that the core presents. A return or a return-from-interrupt pops the most recent address and presents it as a one-cycle jump. The stack is a fixed hardware LIFO of six 12-bit entries. Software has no path to read or write it.

The block also accepts interrupt requests. It keeps four maskable sources and one non-maskable source. When it takes a request, it pushes the current program counter, pulses an acknowledge for the winning source, and issues a jump to that source's fixed vector location. It also moves the core into the interrupt or non-maskable context. Each of the three contexts (normal, interrupt, non-maskable) owns a private carry/zero pair. Only the pair of the current context is visible and writable. A return-from-interrupt restores the context that was active before entry.

Top module: `rstk_ctrl`

## Requirements
- R1: After a synchronous reset the following are all zero: jump_valid, every acknowledge, ovf_flag, udf_flag, ctx, c_out and z_out.
- R2: op_call pushes pc_cur. op_ret or op_reti pops the newest entry. In the cycle after the edge that sees the pop, jump_valid is high for one cycle and jump_addr holds the popped value. Pops return entries in reverse push order for any fill level from 1 to 6.
- R3: A push while six entries are held overwrites the oldest entry and sets ovf_flag, which stays set until reset. The six newest addresses still pop in reverse order.
- R4: A pop while the stack is empty produces no jump_valid, leaves the stack contents unchanged, and sets udf_flag, which stays set until reset.
- R5: Taking an interrupt pushes pc_cur, pulses the matching acknowledge for one cycle, and jumps to the vector location. The vector locations are: source 0 at 0xFF6, source 1 at 0xFF4, source 2 at 0xFF2, source 3 at 0xFF0, and the non-maskable source at 0xFFC.
- R6: Among the pending maskable requests, the lowest index wins. A pending non-maskable request wins over every maskable request.
- R7: Maskable requests are ignored while ctx is 1 or 2. A non-maskable request is ignored while ctx is 2. An ignored request gives no acknowledge, no jump and no context change.
- R8: ctx reads 0 for normal, 1 for interrupt and 2 for non-maskable. A maskable entry sets ctx to 1 and a non-maskable entry sets it to 2. op_reti returns from 2 to the context held before that entry (1 or 0), returns from 1 to 0, and leaves 0 unchanged.
- R9: flag_we writes c_in/z_in into the pair of the context active before the edge. c_out/z_out show the pair of the current context. The other two pairs keep their values.
- R10: When several operations arrive in one cycle, op_call takes precedence over op_ret, and op_ret over op_reti. No interrupt is taken in a cycle that presents any of them; a held request is taken in the next cycle that presents none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_cur | input | 12 | Return address to save on call or interrupt entry |
| op_call | input | 1 | Subroutine call: push pc_cur |
| op_ret | input | 1 | Subroutine return: pop |
| op_reti | input | 1 | Return from interrupt: pop and restore context |
| irq_req | input | 4 | Maskable request lines, level sensitive |
| nmi_req | input | 1 | Non-maskable request, level sensitive |
| flag_we | input | 1 | Write c_in/z_in into the active flag pair |
| c_in | input | 1 | Carry value to write |
| z_in | input | 1 | Zero value to write |
| irq_ack | output | 4 | One-cycle acknowledge per maskable source |
| nmi_ack | output | 1 | One-cycle acknowledge of the non-maskable source |
| jump_valid | output | 1 | Load jump_addr into the program counter |
| jump_addr | output | 12 | Popped return address or vector location |
| ctx | output | 2 | Current context: 0 normal, 1 interrupt, 2 non-maskable |
| c_out | output | 1 | Carry of the active pair |
| z_out | output | 1 | Zero of the active pair |
| ovf_flag | output | 1 | Sticky stack overflow |
| udf_flag | output | 1 | Sticky stack underflow |

## Verification
On every cycle the assertions check the following:
- the fill level stays in range;
- both error flags are sticky;
- an empty pop gives no jump;
- the acknowledges are one-hot;
- a non-maskable acknowledge comes with its vector and context;
- a presented operation blocks interrupt entry;
- an inactive flag pair never changes.

Only the bench scenarios can show:
- the return order for every fill level;
- which entries survive after an overwrite;
- the vector of each source and the winner for every request pattern;
- nested entry and exit order, with each flag pair coming back intact.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  typedef enum logic [1:0] {
    CTX_NORM = 2'd0,
    CTX_INT  = 2'd1,
    CTX_NMI  = 2'd2
  } ctx_e;
endpackage

// File: rtl/rstk_lifo.sv
module rstk_lifo #(
  parameter int AW    = 12,
  parameter int DEPTH = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_data,
  output logic          pop_valid,
  output logic [AW-1:0] pop_data,
  output logic          ovf,
  output logic          udf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, wp_inc, wp_dec;
  logic [CW-1:0] cnt;
  logic          empty, full;

  assign empty  = (cnt == '0);
  assign full   = (cnt == FULL);
  assign wp_inc = (wp == LAST) ? '0 : wp + 1'b1;
  assign wp_dec = (wp == '0) ? LAST : wp - 1'b1;

  // storage: no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (pop && !empty) pop_data <= mem[wp_dec];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp        <= '0;
      cnt       <= '0;
      pop_valid <= 1'b0;
      ovf       <= 1'b0;
      udf       <= 1'b0;
    end else begin
      pop_valid <= pop && !empty;
      if (push) begin
        wp <= wp_inc;
        if (full) ovf <= 1'b1;
        else      cnt <= cnt + 1'b1;
      end else if (pop) begin
        if (empty) udf <= 1'b1;
        else begin
          wp  <= wp_dec;
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst) cnt <= FULL);
  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst) ovf |=> ovf);
  // R4
  udf_sticky_chk: assert property (@(posedge clk) disable iff (rst) udf |=> udf);
  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && empty) |=> (!pop_valid && udf));
endmodule

// File: rtl/rstk_flagbank.sv
module rstk_flagbank #(
  parameter int NBANK = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel,
  input  logic       we,
  input  logic       c_in,
  input  logic       z_in,
  output logic       c_out,
  output logic       z_out
);
  logic [NBANK-1:0] c_q, z_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        c_q[b] <= 1'b0;
        z_q[b] <= 1'b0;
      end else if (we && sel == 2'(b)) begin
        c_q[b] <= c_in;
        z_q[b] <= z_in;
      end
    end

    // R9
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (sel != 2'(b)) |=> ($stable(c_q[b]) && $stable(z_q[b])));
  end

  always_comb begin
    c_out = 1'b0;
    z_out = 1'b0;
    for (int i = 0; i < NBANK; i++) begin
      if (sel == 2'(i)) begin
        c_out = c_q[i];
        z_out = z_q[i];
      end
    end
  end
endmodule

// File: rtl/rstk_ctx.sv
module rstk_ctx
  import rstk_pkg::*;
#(
  parameter int            AW      = 12,
  parameter int            NSRC    = 4,
  parameter logic [AW-1:0] VEC_HI  = 12'hFF6,
  parameter logic [AW-1:0] NMI_VEC = 12'hFFC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_any,
  input  logic            reti_do,
  input  logic [NSRC-1:0] irq_req,
  input  logic            nmi_req,
  output logic            take_irq,
  output logic            take_nmi,
  output logic [NSRC-1:0] grant,
  output logic [AW-1:0]   vec,
  output ctx_e            ctx_q
);
  logic nmi_from_int;

  assign take_nmi = nmi_req && !op_any && (ctx_q != CTX_NMI);
  assign take_irq = (|irq_req) && !op_any && !take_nmi && (ctx_q == CTX_NORM);
  assign grant    = irq_req & (~irq_req + 1'b1);

  always_comb begin
    vec = NMI_VEC;
    if (!take_nmi) begin
      for (int i = 0; i < NSRC; i++) begin
        if (grant[i]) vec = VEC_HI - AW'(2 * i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_q        <= CTX_NORM;
      nmi_from_int <= 1'b0;
    end else if (take_nmi) begin
      ctx_q        <= CTX_NMI;
      nmi_from_int <= (ctx_q == CTX_INT);
    end else if (take_irq) begin
      ctx_q <= CTX_INT;
    end else if (reti_do) begin
      case (ctx_q)
        CTX_NMI: ctx_q <= nmi_from_int ? CTX_INT : CTX_NORM;
        default: ctx_q <= CTX_NORM;
      endcase
    end
  end

  // R8
  ctx_legal_chk: assert property (@(posedge clk) disable iff (rst) ctx_q != 2'd3);
endmodule

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
  import rstk_pkg::*;
#(
  parameter int            AW      = 12,
  parameter int            DEPTH   = 6,
  parameter int            NSRC    = 4,
  parameter logic [AW-1:0] VEC_HI  = 12'hFF6,
  parameter logic [AW-1:0] NMI_VEC = 12'hFFC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   pc_cur,
  input  logic            op_call,
  input  logic            op_ret,
  input  logic            op_reti,
  input  logic [NSRC-1:0] irq_req,
  input  logic            nmi_req,
  input  logic            flag_we,
  input  logic            c_in,
  input  logic            z_in,
  output logic [NSRC-1:0] irq_ack,
  output logic            nmi_ack,
  output logic            jump_valid,
  output logic [AW-1:0]   jump_addr,
  output logic [1:0]      ctx,
  output logic            c_out,
  output logic            z_out,
  output logic            ovf_flag,
  output logic            udf_flag
);
  logic            op_any, reti_do, push, pop;
  logic            take_irq, take_nmi;
  logic [NSRC-1:0] grant;
  logic [AW-1:0]   vec, vec_q;
  logic            vec_valid_q, pop_valid;
  logic [AW-1:0]   pop_data;
  ctx_e            ctx_q;

  assign op_any  = op_call | op_ret | op_reti;
  assign reti_do = op_reti && !op_call && !op_ret;
  assign push    = op_call | take_irq | take_nmi;
  assign pop     = !op_call && (op_ret || op_reti);

  rstk_ctx #(.AW(AW), .NSRC(NSRC), .VEC_HI(VEC_HI), .NMI_VEC(NMI_VEC)) u_ctx (
    .clk(clk), .rst(rst), .op_any(op_any), .reti_do(reti_do),
    .irq_req(irq_req), .nmi_req(nmi_req),
    .take_irq(take_irq), .take_nmi(take_nmi), .grant(grant), .vec(vec),
    .ctx_q(ctx_q)
  );

  rstk_lifo #(.AW(AW), .DEPTH(DEPTH)) u_lifo (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .push_data(pc_cur),
    .pop_valid(pop_valid), .pop_data(pop_data), .ovf(ovf_flag), .udf(udf_flag)
  );

  rstk_flagbank #(.NBANK(3)) u_flags (
    .clk(clk), .rst(rst), .sel(ctx_q), .we(flag_we), .c_in(c_in), .z_in(z_in),
    .c_out(c_out), .z_out(z_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_ack     <= '0;
      nmi_ack     <= 1'b0;
      vec_valid_q <= 1'b0;
      vec_q       <= '0;
    end else begin
      irq_ack     <= take_irq ? grant : '0;
      nmi_ack     <= take_nmi;
      vec_valid_q <= take_irq | take_nmi;
      vec_q       <= vec;
    end
  end

  assign jump_valid = pop_valid | vec_valid_q;
  assign jump_addr  = vec_valid_q ? vec_q : pop_data;
  assign ctx        = ctx_q;

  // R6
  ack_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0({nmi_ack, irq_ack}));
  // R5
  nmi_vec_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_ack |-> (jump_valid && jump_addr == NMI_VEC));
  // R8
  nmi_ctx_chk: assert property (@(posedge clk) disable iff (rst) nmi_ack |-> (ctx == 2'd2));
  // R7
  masked_ctx_chk: assert property (@(posedge clk) disable iff (rst)
    (ctx != 2'd0) |=> (irq_ack == '0));
  // R10
  op_block_chk: assert property (@(posedge clk) disable iff (rst)
    op_any |=> (!nmi_ack && irq_ack == '0));
endmodule

// File: tb/rstk_ctrl_tb.sv
module rstk_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] pc_cur;
  logic        op_call, op_ret, op_reti;
  logic [3:0]  irq_req;
  logic        nmi_req, flag_we, c_in, z_in;
  logic [3:0]  irq_ack;
  logic        nmi_ack, jump_valid;
  logic [11:0] jump_addr;
  logic [1:0]  ctx;
  logic        c_out, z_out, ovf_flag, udf_flag;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rstk_ctrl u_dut (
    .clk(clk), .rst(rst), .pc_cur(pc_cur), .op_call(op_call), .op_ret(op_ret),
    .op_reti(op_reti), .irq_req(irq_req), .nmi_req(nmi_req), .flag_we(flag_we),
    .c_in(c_in), .z_in(z_in), .irq_ack(irq_ack), .nmi_ack(nmi_ack),
    .jump_valid(jump_valid), .jump_addr(jump_addr), .ctx(ctx), .c_out(c_out),
    .z_out(z_out), .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    op_call = 0; op_ret = 0; op_reti = 0; irq_req = '0; nmi_req = 0; flag_we = 0;
  endtask

  task automatic do_reset();
    idle();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic ops(input bit c, input bit r, input bit ri, input logic [11:0] pc);
    pc_cur = pc; op_call = c; op_ret = r; op_reti = ri;
    step();
    idle();
  endtask

  task automatic irq(input logic [3:0] req, input bit nmi, input logic [11:0] pc);
    pc_cur = pc; irq_req = req; nmi_req = nmi;
    step();
    idle();
  endtask

  task automatic wflags(input bit c, input bit z);
    c_in = c; z_in = z; flag_we = 1'b1;
    step();
    idle();
  endtask

  function automatic logic [11:0] pat(input int k);
    return 12'((k * 12'h1A3 + 12'h05C) & 12'hFFF);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    pc_cur = '0; c_in = 0; z_in = 0;
    @(negedge clk);
    do_reset();
    // R1 reset state
    eq("R1", "jump_valid", jump_valid, 0);
    eq("R1", "acks", {nmi_ack, irq_ack}, 0);
    eq("R1", "ctx", ctx, 0);
    eq("R1", "flags c z", {c_out, z_out}, 0);
    eq("R1", "ovf udf", {ovf_flag, udf_flag}, 0);

    // R2 fill levels 1..6, reverse order
    for (int n = 1; n <= 6; n++) begin
      for (int k = 0; k < n; k++) ops(1, 0, 0, pat(n * 8 + k));
      eq("R2", "no jump on call", jump_valid, 0);
      for (int k = n - 1; k >= 0; k--) begin
        ops(0, 1, 0, 12'h0);
        eq("R2", "pop valid", jump_valid, 1);
        eq("R2", "pop addr", jump_addr, pat(n * 8 + k));
        step();
        eq("R2", "pulse width", jump_valid, 0);
      end
    end
    eq("R3", "no ovf at six", ovf_flag, 0);
    eq("R4", "no udf at balanced", udf_flag, 0);

    // R5 vector per source, R8 ctx
    for (int i = 0; i < 4; i++) begin
      irq(4'(1 << i), 0, 12'h300 + 12'(i));
      eq("R5", "ack", irq_ack, 1 << i);
      eq("R5", "vector", jump_addr, 12'hFF6 - 12'(2 * i));
      eq("R5", "jump valid", jump_valid, 1);
      eq("R8", "ctx int", ctx, 1);
      step();
      eq("R5", "ack pulse", irq_ack, 0);
      ops(0, 0, 1, 12'h0);
      eq("R5", "return addr", jump_addr, 12'h300 + 12'(i));
      eq("R8", "ctx back", ctx, 0);
    end

    // R6 all request patterns
    for (int p = 1; p < 16; p++) begin
      int lo;
      lo = 0;
      while (((p >> lo) & 1) == 0) lo++;
      irq(4'(p), 0, 12'h400 + 12'(p));
      eq("R6", "lowest wins", irq_ack, 1 << lo);
      eq("R6", "winner vector", jump_addr, 12'hFF6 - 12'(2 * lo));
      ops(0, 0, 1, 12'h0);
      eq("R6", "return", jump_addr, 12'h400 + 12'(p));
    end
    irq(4'hF, 1, 12'h555);
    eq("R6", "nmi over maskable ack", {nmi_ack, irq_ack}, 5'b10000);
    eq("R5", "nmi vector", jump_addr, 12'hFFC);
    ops(0, 0, 1, 12'h0);
    eq("R8", "nmi from normal back", ctx, 0);

    // R9 R8 R7 nesting with flag pairs
    wflags(1, 0);
    eq("R9", "normal pair", {c_out, z_out}, 2'b10);
    irq(4'h2, 0, 12'h111);
    eq("R9", "int pair fresh", {c_out, z_out}, 2'b00);
    wflags(0, 1);
    eq("R9", "int pair written", {c_out, z_out}, 2'b01);
    irq(4'h1, 0, 12'h222);
    eq("R7", "masked in int ack", irq_ack, 0);
    eq("R7", "masked in int jump", jump_valid, 0);
    eq("R7", "masked in int ctx", ctx, 1);
    irq(4'h0, 1, 12'h333);
    eq("R8", "nmi preempts", ctx, 2);
    eq("R5", "nmi ack", nmi_ack, 1);
    eq("R9", "nmi pair fresh", {c_out, z_out}, 2'b00);
    wflags(1, 1);
    irq(4'h8, 1, 12'h444);
    eq("R7", "ignored in nmi", {nmi_ack, irq_ack, jump_valid}, 0);
    eq("R7", "ctx stays nmi", ctx, 2);
    ops(0, 0, 1, 12'h0);
    eq("R8", "nmi returns to int", ctx, 1);
    eq("R2", "nmi return addr", jump_addr, 12'h333);
    eq("R9", "int pair kept", {c_out, z_out}, 2'b01);
    ops(0, 0, 1, 12'h0);
    eq("R8", "int returns to normal", ctx, 0);
    eq("R2", "int return addr", jump_addr, 12'h111);
    eq("R9", "normal pair kept", {c_out, z_out}, 2'b10);
    irq(4'h0, 1, 12'h666);
    eq("R9", "nmi pair kept", {c_out, z_out}, 2'b11);
    ops(0, 0, 1, 12'h0);

    // R10 precedence
    ops(1, 1, 0, 12'h7A7);
    eq("R10", "call over ret", jump_valid, 0);
    ops(0, 1, 1, 12'h0);
    eq("R10", "ret pops", jump_addr, 12'h7A7);
    eq("R10", "ret over reti ctx", ctx, 0);
    pc_cur = 12'h0AB; irq_req = 4'h4; op_call = 1;
    step();
    op_call = 0;
    eq("R10", "no entry with op", {irq_ack, jump_valid}, 0);
    step();
    idle();
    eq("R10", "entry after op", irq_ack, 4'h4);
    ops(0, 0, 1, 12'h0);
    eq("R10", "entry pushed pc", jump_addr, 12'h0AB);
    ops(0, 1, 0, 12'h0);
    eq("R10", "call pushed pc", jump_addr, 12'h0AB);

    // R3 overwrite, R4 empty pop
    do_reset();
    for (int k = 0; k < 6; k++) ops(1, 0, 0, pat(100 + k));
    eq("R3", "full no ovf", ovf_flag, 0);
    ops(1, 0, 0, pat(106));
    eq("R3", "ovf set", ovf_flag, 1);
    for (int k = 6; k >= 1; k--) begin
      ops(0, 1, 0, 12'h0);
      eq("R3", "newest six", jump_addr, pat(100 + k));
    end
    eq("R3", "ovf sticky", ovf_flag, 1);
    eq("R4", "udf before empty pop", udf_flag, 0);
    ops(0, 1, 0, 12'h0);
    eq("R4", "no jump on empty", jump_valid, 0);
    eq("R4", "udf set", udf_flag, 1);
    ops(1, 0, 0, 12'h9C3);
    ops(0, 1, 0, 12'h0);
    eq("R4", "stack intact", jump_addr, 12'h9C3);
    eq("R4", "udf sticky", udf_flag, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule